// File: doc/BRIEF.md
# Latched Four-Phase Branch Selector

This block sits on the control path of a handshake-sequenced state machine. It takes one four-phase request and sends it to one of two branch request lines, the true branch or the false branch, according to a level-sensitive branch condition. Whichever branch is chosen returns its acknowledge, and the block passes that acknowledge back to the requester as the input acknowledge.

A mode parameter selects one of two forms. The combinational form is a plain demultiplexer. It is only safe when the condition stays stable for as long as the request is high. The latched form captures the condition when the request arrives and holds it until the request returns to zero. A step inside the branch can therefore change the condition without moving the active path. While no request is pending, the latch follows the condition freely.

The model is clocked. All four inputs from the handshake and the condition pass through a synchroniser of `SYNC_STAGES` flops. All three outputs are registered. An input change that lands just before a clock edge therefore shows up at the outputs `SYNC_STAGES`+1 rising edges later.

Top module: `branch_sel`

## Requirements
- R1: While `rstN` is low, `trueReq`, `falseReq` and `inAck` are all 0 whatever the inputs are, and the captured condition is cleared to 0.
- R2: When a change on `inReq` is presented before a rising edge, the selected branch request shows it at the (`SYNC_STAGES`+1)th rising edge, not before. `trueReq` is the selected line when the condition is 1, and `falseReq` when it is 0.
- R3: The branch request that is not selected stays 0, so `trueReq` and `falseReq` are never 1 together.
- R4: In latched mode (`MODE` = `SEL_LATCH`, encoded 1), the condition is sampled on the first clock in which the synchronised request is seen high. Later changes of `branchCond` do not change either branch request until the request falls.
- R5: In latched mode, while the request is low the latch is transparent. The condition value present when the next request arrives decides that request's branch, whatever values it took before.
- R6: In combinational mode (`MODE` = `SEL_COMB`, encoded 0), a change of `branchCond` while the request is high moves the active request to the other branch after the same latency as R2.
- R7: `inAck` is the OR of `trueAck` and `falseAck`. It is seen `SYNC_STAGES`+1 rising edges after the acknowledge changes, and it is not gated by the input request.
- R8: When `inReq` falls, both branch requests return to 0 after the R2 latency, even while the branch acknowledge is still high.
- R9: In latched mode, if the condition changes in the same cycle that the request rises, the new condition value is the one captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inReq | input | 1 | Four-phase request from the previous step |
| inAck | output | 1 | Acknowledge returned to the previous step |
| branchCond | input | 1 | Branch condition level, 1 picks the true branch |
| trueReq | output | 1 | Request to the true branch |
| trueAck | input | 1 | Acknowledge from the true branch |
| falseReq | output | 1 | Request to the false branch |
| falseAck | input | 1 | Acknowledge from the false branch |

## Verification
The bench drives a latched and a combinational instance side by side. While a request is active it changes the condition on every cycle, using random values. If the latch were left transparent while the request is high, the active path would jump to the other branch mid-handshake. In the combinational instance, a selector that wrongly held its value would fail to follow the condition. A condition change in the same cycle as the request edge is also tested; capturing one cycle late would take the stale value. The bench lowers the request while the branch acknowledge is still high, which catches a selector that gates the return-to-zero on the acknowledge. It also checks exact latency, so an extra or missing register stage is caught.

// File: rtl/branch_sel_pkg.sv
`timescale 1ns/1ps
package branch_sel_pkg;

  typedef enum logic {
    SEL_COMB  = 1'b0,
    SEL_LATCH = 1'b1
  } selMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // first cycle the synchronised request is high
    logic useLatch;  // request high and condition already captured
    logic open;      // request low: latch is transparent
  } selStrb_t;

endpackage

// File: rtl/branch_sel_sync.sv
`timescale 1ns/1ps
module branch_sel_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= dIn;
      for (int s = 1; s < STAGES; s++) begin
        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign dOut = stageQ[LAST];

  initial begin
    a_stages_r2: assert (STAGES >= 1);
  end

endmodule

// File: rtl/branch_sel_ctrl.sv
`timescale 1ns/1ps
module branch_sel_ctrl
  import branch_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqS,
  output selStrb_t strb
);

  logic reqSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSeen <= 1'b0;
    else       reqSeen <= reqS;
  end

  always_comb begin
    strb.capture  = reqS & ~reqSeen;
    strb.useLatch = reqS &  reqSeen;
    strb.open     = ~reqS;
  end

  // capture and hold are never both active (R4)
  p_strb_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capture && strb.useLatch));

  // a capture is followed by a hold while the request persists (R4)
  p_capture_then_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && reqS) |=> (strb.useLatch || !reqS));

endmodule

// File: rtl/branch_sel_dp.sv
`timescale 1ns/1ps
module branch_sel_dp
  import branch_sel_pkg::*;
#(
  parameter selMode_e MODE = SEL_LATCH
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqS,
  input  logic     condS,
  input  logic     tAckS,
  input  logic     fAckS,
  input  selStrb_t strb,
  output logic     trueReq,
  output logic     falseReq,
  output logic     inAck
);

  logic selCond;
  logic trueReqQ, falseReqQ, inAckQ;

  generate
    if (MODE == SEL_LATCH) begin : g_latch
      logic condLatch;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          condLatch <= 1'b0;
        else if (strb.capture || strb.open) condLatch <= condS;
      end

      assign selCond = strb.useLatch ? condLatch : condS;

      // active branch holds while the request stays high (R4)
      p_hold_true_r4: assert property (@(posedge clk) disable iff (!rstN)
        (trueReq && reqS) |=> trueReq);
      p_hold_false_r4: assert property (@(posedge clk) disable iff (!rstN)
        (falseReq && reqS) |=> falseReq);
    end else begin : g_comb
      assign selCond = condS;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trueReqQ  <= 1'b0;
      falseReqQ <= 1'b0;
      inAckQ    <= 1'b0;
    end else begin
      trueReqQ  <= reqS &  selCond;
      falseReqQ <= reqS & ~selCond;
      inAckQ    <= tAckS | fAckS;
    end
  end

  assign trueReq  = trueReqQ;
  assign falseReq = falseReqQ;
  assign inAck    = inAckQ;

  // never both branches (R3)
  p_one_branch_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trueReq, falseReq}));

  // a synchronised request yields some branch request (R2)
  p_req_routed_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqS |=> (trueReq || falseReq));

  // request low returns both branch requests to zero (R8)
  p_rtz_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqS |=> (!trueReq && !falseReq));

  // acknowledge merge (R7)
  p_ack_true_r7: assert property (@(posedge clk) disable iff (!rstN)
    tAckS |=> inAck);
  p_ack_false_r7: assert property (@(posedge clk) disable iff (!rstN)
    fAckS |=> inAck);

  // reset holds everything low (R1)
  always @(negedge clk) begin
    if (!rstN) begin
      a_reset_quiet_r1: assert (!trueReq && !falseReq && !inAck);
    end
  end

endmodule

// File: rtl/branch_sel.sv
`timescale 1ns/1ps
module branch_sel
  import branch_sel_pkg::*;
#(
  parameter selMode_e MODE        = SEL_LATCH,
  parameter int       SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic inReq,
  output logic inAck,
  input  logic branchCond,
  output logic trueReq,
  input  logic trueAck,
  output logic falseReq,
  input  logic falseAck
);

  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic reqS, condS, tAckS, fAckS;
  selStrb_t strb;

  assign rawIn = {inReq, branchCond, trueAck, falseAck};
  assign {reqS, condS, tAckS, fAckS} = syncOut;

  branch_sel_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .dIn (rawIn),
    .dOut(syncOut)
  );

  branch_sel_ctrl ctrl_i (
    .clk (clk),
    .rstN(rstN),
    .reqS(reqS),
    .strb(strb)
  );

  branch_sel_dp #(.MODE(MODE)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqS    (reqS),
    .condS   (condS),
    .tAckS   (tAckS),
    .fAckS   (fAckS),
    .strb    (strb),
    .trueReq (trueReq),
    .falseReq(falseReq),
    .inAck   (inAck)
  );

endmodule

// File: tb/branch_sel_tb_top.sv
`timescale 1ns/1ps
module branch_sel_tb_top;
  import branch_sel_pkg::*;

  localparam int LAT = 3;   // SYNC_STAGES + output register

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inReq = 1'b0, branchCond = 1'b0, trueAck = 1'b0, falseAck = 1'b0;
  logic inAck, trueReq, falseReq;
  logic cInAck, cTrueReq, cFalseReq;

  int nChecks = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  branch_sel #(.MODE(SEL_LATCH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inAck(inAck),
    .branchCond(branchCond), .trueReq(trueReq), .trueAck(trueAck),
    .falseReq(falseReq), .falseAck(falseAck)
  );

  branch_sel #(.MODE(SEL_COMB), .SYNC_STAGES(2)) dutComb_i (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inAck(cInAck),
    .branchCond(branchCond), .trueReq(cTrueReq), .trueAck(trueAck),
    .falseReq(cFalseReq), .falseAck(falseAck)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic t_reset;
    inReq = 1'b1; branchCond = 1'b1; trueAck = 1'b1; falseAck = 1'b1;
    tick(5);
    chk("R1", "trueReq in reset", trueReq, 1'b0);
    chk("R1", "falseReq in reset", falseReq, 1'b0);
    chk("R1", "inAck in reset", inAck, 1'b0);
    inReq = 1'b0; branchCond = 1'b0; trueAck = 1'b0; falseAck = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(LAT + 2);
    chk("R1", "trueReq after reset", trueReq, 1'b0);
  endtask

  task automatic t_true_path;
    branchCond = 1'b1;
    tick(LAT + 2);
    inReq = 1'b1;
    tick(LAT - 1);
    chk("R2", "trueReq one cycle early", trueReq, 1'b0);
    tick(1);
    chk("R2", "trueReq at latency", trueReq, 1'b1);
    chk("R3", "falseReq idle", falseReq, 1'b0);
    trueAck = 1'b1;
    tick(LAT - 1);
    chk("R7", "inAck one cycle early", inAck, 1'b0);
    tick(1);
    chk("R7", "inAck from true", inAck, 1'b1);
    inReq = 1'b0;
    tick(LAT + 1);
    chk("R8", "trueReq falls with ack high", trueReq, 1'b0);
    chk("R7", "inAck held by ack", inAck, 1'b1);
    trueAck = 1'b0;
    tick(LAT + 1);
    chk("R7", "inAck released", inAck, 1'b0);
  endtask

  task automatic t_false_path;
    branchCond = 1'b0;
    tick(LAT + 2);
    inReq = 1'b1;
    tick(LAT + 1);
    chk("R2", "falseReq routed", falseReq, 1'b1);
    chk("R3", "trueReq stays low", trueReq, 1'b0);
    falseAck = 1'b1;
    tick(LAT + 1);
    chk("R7", "inAck from false", inAck, 1'b1);
    inReq = 1'b0;
    tick(LAT + 1);
    chk("R8", "falseReq falls", falseReq, 1'b0);
    falseAck = 1'b0;
    tick(LAT + 1);
    chk("R7", "inAck low", inAck, 1'b0);
  endtask

  task automatic t_hold_latched;
    branchCond = 1'b1;
    tick(LAT + 2);
    inReq = 1'b1;
    tick(LAT + 1);
    chk("R4", "true taken", trueReq, 1'b1);
    for (int i = 0; i < 40; i++) begin
      branchCond = 1'($urandom);
      tick(1);
      chk("R4", "trueReq held under toggling", trueReq, 1'b1);
      chk("R4", "falseReq held low under toggling", falseReq, 1'b0);
    end
    branchCond = 1'b0;
    tick(LAT + 2);
    chk("R4", "latched keeps true", trueReq, 1'b1);
    chk("R6", "comb moved to false", cFalseReq, 1'b1);
    chk("R6", "comb left true", cTrueReq, 1'b0);
    branchCond = 1'b1;
    tick(LAT + 1);
    chk("R6", "comb back to true", cTrueReq, 1'b1);
    inReq = 1'b0;
    tick(LAT + 2);
    chk("R8", "latched true low", trueReq, 1'b0);
    chk("R8", "comb true low", cTrueReq, 1'b0);
  endtask

  task automatic t_transparent;
    branchCond = 1'b1; tick(LAT);
    branchCond = 1'b0; tick(1);
    branchCond = 1'b1; tick(1);
    branchCond = 1'b0; tick(LAT + 2);
    inReq = 1'b1;
    tick(LAT + 1);
    chk("R5", "latest idle condition used", falseReq, 1'b1);
    chk("R5", "stale condition not used", trueReq, 1'b0);
    inReq = 1'b0;
    tick(LAT + 2);
  endtask

  task automatic t_same_edge;
    branchCond = 1'b1;
    tick(LAT + 2);
    inReq = 1'b1; branchCond = 1'b0;
    tick(1);
    branchCond = 1'b1;
    tick(LAT + 2);
    chk("R9", "same-edge condition captured", falseReq, 1'b1);
    chk("R9", "later condition ignored", trueReq, 1'b0);
    inReq = 1'b0;
    tick(LAT + 2);
    chk("R8", "idle after same-edge case", falseReq, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    t_reset();
    t_true_path();
    t_false_path();
    t_hold_latched();
    t_transparent();
    t_same_edge();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule